// File: doc/BRIEF.md
# Prefix-Code Tree Walk Decoder

This block decodes a single variable-length prefix code of up to six bits. A 64-bit tree descriptor marks, one bit per node, which nodes of a complete binary tree end a valid code. Its two lowest bits are not tree nodes; they carry a 2-bit mode. The pending code bits arrive in a 64-bit primary word, least significant bit first, with a single 1 above the last data bit that marks where the data ends. When the primary word runs dry in the middle of a code, a secondary word can be used once to supply more bits.

The whole walk is one combinational chain of six identical step stages feeding a registered output stage. A two-state handshake controller accepts one request when `in_ready` is high and presents the result with `out_valid` on the next cycle. It holds that result until `out_ready` is seen. The result is either the tree node index where the walk stopped or a dense symbol number, depending on the mode. The controller also returns the unused part of the input word and four status flags.

The controller has two states. `ST_EMPTY` waits with `in_ready` high; the ACCEPT transition (`in_valid` high) loads the output registers and moves to `ST_HOLD`. `ST_HOLD` drives `out_valid`; the RELEASE transition (`out_ready` high) returns to `ST_EMPTY`.

Top module: `pfx_tree_decoder`

## Requirements
- R1: The mode is `in_tree[1:0]`. Those two bits are cleared from the tree bitmap before the walk, so they never mark a code and never count toward a symbol number.
- R2: A primary word of zero is handled exactly like a primary word of 1, which means no data bits remain.
- R3: The walk starts at node index 1. Each data bit is taken from bit 0 of the current word, the word is shifted right by one with a zero entering at the top, and the index becomes 2*index + bit.
- R4: The walk stops with found set as soon as tree bitmap bit [index] is 1 while index < 64. Found and hit-end are never both set.
- R5: If no code is found after six bits, the index is 64 or more and the overflow flag is set.
- R6: When the word equals 1 and the secondary source is enabled and not yet used, the secondary word replaces the word and the refill flag is set. If the secondary word is 0 or 1, it is empty and hit-end is set.
- R7: When the word equals 1 and the secondary word has already been used or is disabled, hit-end is set and the walk stops.
- R8: Modes 0 and 2 restore the input when no code was found; modes 1 and 3 restore it when hit-end is set. Restoring returns the original primary word (zero read as 1) as the leftover word and clears the refill flag. Otherwise the leftover word is the shifted word at the point where the walk stopped.
- R9: Modes 0 and 1 return the final node index. Modes 2 and 3 return the number of set bitmap bits (after R1) at indices below the final index. Both are zero-extended to 64 bits.
- R10: The status bits are [3] refill used, [2] index >= 64, [1] found, [0] hit-end.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1. An accepted request gives `out_valid` on the next cycle. The outputs stay stable, and `in_ready` stays low, until `out_ready` is seen; the cycle after that, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_tree | input | 64 | Tree bitmap, mode in bits 1:0 |
| in_bits | input | 64 | Primary code word with end marker |
| in_sec | input | 64 | Secondary refill word |
| in_sec_en | input | 1 | Secondary source enabled |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Node index or symbol number |
| out_rest | output | 64 | Leftover input word |
| out_status | output | 4 | Refill, overflow, found, hit-end |

## Verification
The bench builds the block with its defaults: a six-level tree and 64-bit words. With these values, a request with too few primary bits needs the secondary word partway through a code. A bitmap with no marked nodes runs all six steps and crosses index 64. Random words with 0 to 8 data bits and random bitmaps cover every mode against both restore conditions. Directed cases cover the empty primary word, an empty secondary word, and results held while `out_ready` stays low.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [1:0] {
        MODE_NODE_MISS = 2'd0,
        MODE_NODE_END  = 2'd1,
        MODE_SYM_MISS  = 2'd2,
        MODE_SYM_END   = 2'd3
    } pfx_mode_e;

    typedef struct packed {
        logic refill;
        logic overflow;
        logic found;
        logic hit_end;
    } pfx_status_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } pfx_state_e;

endpackage

// File: rtl/pfx_step.sv
module pfx_step #(
    parameter int WORD_W = 64,
    parameter int IDX_W  = 7,
    parameter int TREE_W = 64
) (
    input  logic [TREE_W-1:0] tree,
    input  logic [WORD_W-1:0] sec,
    input  logic              sec_en,
    input  logic [WORD_W-1:0] w_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              used_i,
    input  logic              found_i,
    input  logic              end_i,
    output logic [WORD_W-1:0] w_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              used_o,
    output logic              found_o,
    output logic              end_o
);

    logic [WORD_W-1:0] cur;
    logic              take;

    always_comb begin
        w_o     = w_i;
        idx_o   = idx_i;
        used_o  = used_i;
        found_o = found_i;
        end_o   = end_i;
        cur     = w_i;
        take    = 1'b0;
        if (!found_i && !end_i) begin
            if (w_i == WORD_W'(1)) begin
                if (used_i || !sec_en) begin
                    end_o = 1'b1;
                end else begin
                    used_o = 1'b1;
                    cur    = sec;
                    if (sec <= WORD_W'(1)) end_o = 1'b1;
                    else                   take  = 1'b1;
                end
            end else begin
                take = 1'b1;
            end
            if (take) begin
                w_o     = cur >> 1;
                idx_o   = {idx_i[IDX_W-2:0], cur[0]};
                found_o = ~idx_o[IDX_W-1] & tree[idx_o[IDX_W-2:0]];
            end
        end
    end

endmodule

// File: rtl/pfx_popcnt.sv
module pfx_popcnt #(
    parameter int TREE_W = 64,
    parameter int IDX_W  = 7
) (
    input  logic [TREE_W-1:0] tree,
    input  logic [IDX_W-1:0]  limit,
    output logic [IDX_W-1:0]  count
);

    always_comb begin
        count = '0;
        for (int j = 0; j < TREE_W; j++) begin
            if (IDX_W'(j) < limit) count = count + IDX_W'(tree[j]);
        end
    end

endmodule

// File: rtl/pfx_walk.sv
module pfx_walk
    import pfx_pkg::*;
#(
    parameter int WORD_W  = 64,
    parameter int MAX_LEN = 6
) (
    input  logic [(1<<MAX_LEN)-1:0] tree_raw,
    input  logic [WORD_W-1:0]       bits,
    input  logic [WORD_W-1:0]       sec,
    input  logic                    sec_en,
    output logic [WORD_W-1:0]       result,
    output logic [WORD_W-1:0]       rest,
    output pfx_status_t             status
);

    localparam int TREE_W = 1 << MAX_LEN;
    localparam int IDX_W  = MAX_LEN + 1;

    pfx_mode_e         mode;
    logic [TREE_W-1:0] tree;
    logic [WORD_W-1:0] orig;

    logic [WORD_W-1:0] w_c     [0:MAX_LEN];
    logic [IDX_W-1:0]  idx_c   [0:MAX_LEN];
    logic              used_c  [0:MAX_LEN];
    logic              found_c [0:MAX_LEN];
    logic              end_c   [0:MAX_LEN];

    logic [IDX_W-1:0]  sym;
    logic              restore;

    assign mode = pfx_mode_e'(tree_raw[1:0]);
    assign tree = tree_raw & ~TREE_W'(3);
    assign orig = (bits == '0) ? WORD_W'(1) : bits;

    assign w_c[0]     = orig;
    assign idx_c[0]   = IDX_W'(1);
    assign used_c[0]  = 1'b0;
    assign found_c[0] = 1'b0;
    assign end_c[0]   = 1'b0;

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_step
        pfx_step #(
            .WORD_W (WORD_W),
            .IDX_W  (IDX_W),
            .TREE_W (TREE_W)
        ) u_step (
            .tree    (tree),
            .sec     (sec),
            .sec_en  (sec_en),
            .w_i     (w_c[g]),
            .idx_i   (idx_c[g]),
            .used_i  (used_c[g]),
            .found_i (found_c[g]),
            .end_i   (end_c[g]),
            .w_o     (w_c[g+1]),
            .idx_o   (idx_c[g+1]),
            .used_o  (used_c[g+1]),
            .found_o (found_c[g+1]),
            .end_o   (end_c[g+1])
        );
    end

    pfx_popcnt #(
        .TREE_W (TREE_W),
        .IDX_W  (IDX_W)
    ) u_popcnt (
        .tree  (tree),
        .limit (idx_c[MAX_LEN]),
        .count (sym)
    );

    always_comb begin
        unique case (mode)
            MODE_NODE_MISS, MODE_SYM_MISS: restore = ~found_c[MAX_LEN];
            MODE_NODE_END,  MODE_SYM_END:  restore = end_c[MAX_LEN];
            default:                       restore = 1'b0;
        endcase
        unique case (mode)
            MODE_NODE_MISS, MODE_NODE_END: result = WORD_W'(idx_c[MAX_LEN]);
            MODE_SYM_MISS,  MODE_SYM_END:  result = WORD_W'(sym);
            default:                       result = '0;
        endcase
        rest            = restore ? orig : w_c[MAX_LEN];
        status.refill   = restore ? 1'b0 : used_c[MAX_LEN];
        status.overflow = idx_c[MAX_LEN][IDX_W-1];
        status.found    = found_c[MAX_LEN];
        status.hit_end  = end_c[MAX_LEN];
    end

endmodule

// File: rtl/pfx_tree_decoder.sv
module pfx_tree_decoder
    import pfx_pkg::*;
#(
    parameter int WORD_W  = 64,
    parameter int MAX_LEN = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [(1<<MAX_LEN)-1:0] in_tree,
    input  logic [WORD_W-1:0]       in_bits,
    input  logic [WORD_W-1:0]       in_sec,
    input  logic                    in_sec_en,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [WORD_W-1:0]       out_result,
    output logic [WORD_W-1:0]       out_rest,
    output logic [3:0]              out_status
);

    pfx_state_e        state, state_nxt;
    logic [WORD_W-1:0] walk_result, walk_rest;
    pfx_status_t       walk_status;
    logic [WORD_W-1:0] result_q, rest_q;
    pfx_status_t       status_q;
    logic              accept;

    pfx_walk #(
        .WORD_W  (WORD_W),
        .MAX_LEN (MAX_LEN)
    ) u_walk (
        .tree_raw (in_tree),
        .bits     (in_bits),
        .sec      (in_sec),
        .sec_en   (in_sec_en),
        .result   (walk_result),
        .rest     (walk_rest),
        .status   (walk_status)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (in_valid)  state_nxt = ST_HOLD;
            ST_HOLD:  if (out_ready) state_nxt = ST_EMPTY;
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            ST_EMPTY: in_ready  = 1'b1;
            ST_HOLD:  out_valid = 1'b1;
            default:  in_ready  = 1'b0;
        endcase
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            rest_q   <= '0;
            status_q <= '0;
        end else if (accept) begin
            result_q <= walk_result;
            rest_q   <= walk_rest;
            status_q <= walk_status;
        end
    end

    assign out_result = result_q;
    assign out_rest   = rest_q;
    assign out_status = status_q;

endmodule

// File: rtl/pfx_tree_decoder_chk.sv
module pfx_tree_decoder_chk #(
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_mode,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_result,
    input logic [3:0]        out_status
);

    logic [1:0] cap_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cap_mode <= 2'd0;
        else if (in_valid && in_ready) cap_mode <= in_mode;
    end

    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_status));

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid);

    p_found_end_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_status[1] && out_status[0]));

    p_found_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_status[1] |-> !out_status[2]);

    p_node_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_status[1] && !cap_mode[1] |-> out_result >= 2 && out_result < 64);

    p_miss_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !cap_mode[0] && !out_status[1] |-> !out_status[3]);

    p_end_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cap_mode[0] && out_status[0] |-> !out_status[3]);

endmodule

bind pfx_tree_decoder pfx_tree_decoder_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_mode    (in_tree[1:0]),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_status (out_status)
);

// File: tb/pfx_tree_decoder_test.sv
module pfx_tree_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_tree = '0;
    logic [63:0] in_bits = '0;
    logic [63:0] in_sec = '0;
    logic        in_sec_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_result;
    logic [63:0] out_rest;
    logic [3:0]  out_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pfx_tree_decoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_tree    (in_tree),
        .in_bits    (in_bits),
        .in_sec     (in_sec),
        .in_sec_en  (in_sec_en),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_result (out_result),
        .out_rest   (out_rest),
        .out_status (out_status)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void ref_model(input logic [63:0] t, input logic [63:0] b,
                                      input logic [63:0] s, input logic en,
                                      output logic [63:0] res, output logic [63:0] rest,
                                      output logic [3:0] st);
        logic [1:0]  mode;
        logic [63:0] tr, w, orig;
        logic        used, found, he, restore;
        int          ti, cnt;
        mode = t[1:0];
        tr = t & ~64'h3;
        w = (b == 0) ? 64'd1 : b;
        orig = w;
        used = 0; found = 0; he = 0; ti = 1;
        for (int i = 0; i < 6; i++) begin
            if (!found && !he) begin
                if (w == 1) begin
                    if (used || !en) he = 1;
                    else begin
                        used = 1;
                        w = s;
                        if (s <= 1) he = 1;
                    end
                end
                if (!he) begin
                    ti = ti * 2 + int'(w[0]);
                    w = w >> 1;
                    if (ti < 64 && tr[ti]) found = 1;
                end
            end
        end
        cnt = 0;
        for (int j = 0; j < 64; j++) if (j < ti && tr[j]) cnt++;
        restore = mode[0] ? he : !found;
        if (restore) begin
            w = orig;
            used = 0;
        end
        res = mode[1] ? 64'(cnt) : 64'(ti);
        rest = w;
        st = {used, (ti >= 64), found, he};
    endfunction

    task automatic run(input string req, input logic [63:0] t, input logic [63:0] b,
                       input logic [63:0] s, input logic en, input int hold);
        logic [63:0] e_res, e_rest;
        logic [3:0]  e_st;
        ref_model(t, b, s, en, e_res, e_rest, e_st);
        @(negedge clk);
        in_tree = t; in_bits = b; in_sec = s; in_sec_en = en;
        in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        in_bits = ~b;
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " result"}, out_result, e_res);
        check({req, " rest"}, out_rest, e_rest);
        check({req, " status"}, 64'(out_status), 64'(e_st));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check("R11 hold valid", 64'(out_valid), 64'd1);
            check("R11 hold ready", 64'(in_ready), 64'd0);
            check("R11 hold result", out_result, e_res);
            check("R11 hold status", 64'(out_status), 64'(e_st));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        if (hold > 0) begin
            check("R11 release valid", 64'(out_valid), 64'd0);
            check("R11 release ready", 64'(in_ready), 64'd1);
        end
    endtask

    function automatic logic [63:0] rand_word();
        int          k;
        logic [63:0] r;
        k = int'($urandom % 9);
        r = {$urandom, $urandom};
        if ($urandom % 16 == 0) return 64'd0;
        if ($urandom % 16 == 1) return r;
        return (r & ((64'd1 << k) - 1)) | (64'd1 << k);
    endfunction

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check("R11 reset valid", 64'(out_valid), 64'd0);
        check("R11 reset ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R4: codes "0" and "1" at nodes 2,3; one data bit 0
        run("R3 R4 mode0 single bit", 64'h0C, 64'b10, 64'd0, 1'b0, 0);
        // R9: symbol number of node 3 is 1
        run("R9 mode2 symbol", 64'h0E, 64'b11, 64'd0, 1'b0, 0);
        // R5: empty bitmap, six zeros, mode 0 restores
        run("R5 R8 overflow restore", 64'h0, 64'h400, 64'd0, 1'b0, 0);
        // R5 R8: mode 1 overflow without restore
        run("R5 R8 overflow keep", 64'h1, 64'h400, 64'd0, 1'b0, 0);
        // R1 R2 R7: mode bits only, zero primary, no secondary
        run("R1 R2 R7 empty input", 64'h3, 64'h0, 64'd0, 1'b0, 0);
        // R6: code "00" split across primary and secondary
        run("R6 refill found", 64'h11, 64'b10, 64'b10, 1'b1, 0);
        // R6: empty secondary word
        run("R6 R7 empty secondary", 64'h2, 64'h1, 64'h0, 1'b1, 0);
        // R7: secondary disabled mid code
        run("R7 disabled secondary", 64'h10, 64'b10, 64'b10, 1'b0, 0);
        // R1: mode bits must not act as nodes or symbols
        run("R1 mode bits not counted", 64'h83, 64'b111, 64'd0, 1'b0, 0);
        // R11: hold with out_ready low
        run("R11 held result", 64'hF0, 64'b1100, 64'd0, 1'b0, 3);
        for (int n = 0; n < 400; n++) begin
            logic [63:0] t;
            t = {$urandom, $urandom};
            if (n % 5 == 0) t = t & 64'hFFFF_0000_0000_0003;
            run("R8 R9 R10 random", t, rand_word(), rand_word(), 1'($urandom % 2),
                int'($urandom % 3));
        end
        finish_run();
    end

endmodule